// File: doc/BRIEF.md
# Page-Write Nonvolatile Memory Emulator

This block is a synchronous, cycle-based model of a byte-wide parallel nonvolatile memory. It is meant to sit in a simulation or emulation environment in place of a real part. Three active-low strobes are sampled on every rising clock edge: a select, an output enable and a write enable. The bidirectional data bus is split into an input byte, an output byte and an output-drive flag.

Write cycles fill a page buffer. All bytes taken into one load window must belong to the same page. Once the bus has been quiet for a set number of cycles, a self-timed programming phase starts. It lasts a fixed number of clocks and ends by copying every loaded byte into the storage array, with no erase step. While that phase runs, reads do not return plain array contents. They return two status bits that software can poll: the top bit is the inverse of the top bit of the last byte written, and the next bit flips on every read. A busy output is high for the whole programming phase.

Top module: `pagemem_emu`

## Requirements
- R1: After reset, `busy` and `rdata_oe` are 0 and every array byte reads as 0x00.
- R2: A cycle with `sel_n`=0, `out_en_n`=0 and `wr_en_n`=1 is a read. In that same cycle `rdata_oe` is 1 and `rdata` carries the array byte at `addr` (outside programming).
- R3: Any other strobe combination leaves `rdata_oe` at 0 and `rdata` at 0x00. This includes `sel_n`=1, and it includes `out_en_n`=0 together with `wr_en_n`=0. None of these combinations loads a byte or starts programming.
- R4: A cycle with `sel_n`=0, `out_en_n`=1 and `wr_en_n`=0 is a write, and loads `wdata` for `addr`. Several writes to one address in a window keep the last value. A committed byte simply replaces the old one.
- R5: The page is `addr[ADDR_W-1:8]` (256 bytes per page). The first accepted write of a window fixes the page, and later writes to another page in that window are ignored.
- R6: A write joins the open window if it comes no more than WINDOW cycles after the previous accepted write. `busy` rises exactly WINDOW cycles after the last accepted write.
- R7: `busy` stays high for exactly PROG_CYCLES cycles. The array keeps its old contents until `busy` falls, and only loaded bytes change.
- R8: Write cycles while `busy` is high are ignored. They change no byte and start no new programming phase.
- R9: A read while `busy` is high drives `rdata[7]` as the inverse of bit 7 of the last accepted written byte.
- R10: During a programming phase, `rdata[6]` is 0 on the first read and flips after each read cycle. Non-read cycles leave it unchanged. `rdata[5:0]` carries the old array bits.
- R11: Once `busy` has fallen, reads return the true stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low device select |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data from the bus |
| rdata | output | DATA_W | Read data onto the bus |
| rdata_oe | output | 1 | High when the block drives the bus |
| busy | output | 1 | High during the programming phase |

## Verification
Some properties are checked by assertions on every cycle:
- the bus is driven only during read cycles and is zero otherwise;
- `busy` rises only after exactly WINDOW quiet cycles and lasts exactly PROG_CYCLES;
- the page buffer is frozen while programming;
- bit 6 differs between back-to-back polled reads.

Other behaviour can only be shown by the bench scenarios. These cover:
- the inverted top bit for both polarities of the last byte;
- a foreign-page write and a write during programming being dropped;
- last-value-wins inside one window;
- the old data staying visible until commit.

// File: rtl/pagemem_pkg.sv
// Package: shared types for the page-write memory emulator.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package pagemem_pkg;

    // Controller phase: no open window, collecting bytes, self-timed programming.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pm_state_e;

    // Access decoded from the three strobes in one cycle.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } pm_acc_e;

endpackage

// File: rtl/pagemem_ctrl.sv
// Module: pagemem_ctrl
// Decodes the strobes into read/write accesses and runs the load-window and
// programming-phase sequencer. It decides which write cycles are accepted
// into the page buffer and when the buffer is committed.
// Assumes: WINDOW >= 1 and PROG_CYCLES >= 1; strobes are synchronous to clk.
module pagemem_ctrl
    import pagemem_pkg::*;
#(
    parameter int PG_W        = 2,
    parameter int WINDOW      = 8,
    parameter int PROG_CYCLES = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_n,
    input  logic            out_en_n,
    input  logic            wr_en_n,
    input  logic [PG_W-1:0] page_i,
    output pm_acc_e         acc_o,
    output logic            load_o,
    output logic            commit_o,
    output logic            busy_o,
    output logic [PG_W-1:0] page_o
);

    localparam int LONGEST = (WINDOW > PROG_CYCLES) ? WINDOW : PROG_CYCLES;
    localparam int CNT_W   = $clog2(LONGEST + 2);

    pm_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PG_W-1:0]  page_q;
    logic             win_end;

    // Strobe decode: exactly one of read, write or nothing per cycle.
    always_comb begin
        if (!sel_n && !out_en_n && wr_en_n) begin
            acc_o = ACC_READ;
        end else if (!sel_n && out_en_n && !wr_en_n) begin
            acc_o = ACC_WRITE;
        end else begin
            acc_o = ACC_NONE;
        end
    end

    // Acceptance, window expiry and commit conditions.
    always_comb begin
        load_o   = (acc_o == ACC_WRITE) &&
                   ((state_q == ST_IDLE) ||
                    ((state_q == ST_LOAD) && (page_i == page_q)));
        win_end  = (state_q == ST_LOAD) && !load_o &&
                   (cnt_q == CNT_W'(WINDOW - 1));
        commit_o = (state_q == ST_PROG) && (cnt_q == CNT_W'(PROG_CYCLES - 1));
    end

    // Phase sequencer with a shared cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            page_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (load_o) begin
                        state_q <= ST_LOAD;
                        page_q  <= page_i;
                        cnt_q   <= '0;
                    end
                end
                ST_LOAD: begin
                    if (load_o) begin
                        cnt_q <= '0;
                    end else if (win_end) begin
                        state_q <= ST_PROG;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (commit_o) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign busy_o = (state_q == ST_PROG);
    assign page_o = page_q;

    // Checker state: quiet cycles since the last accepted write, and busy run length.
    logic [CNT_W-1:0] quiet_q;
    logic [CNT_W-1:0] busy_len_q;

    // Count quiet and busy cycles independently of the sequencer counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q    <= '0;
            busy_len_q <= '0;
        end else begin
            if (load_o) begin
                quiet_q <= '0;
            end else if (quiet_q < CNT_W'(WINDOW + 1)) begin
                quiet_q <= quiet_q + 1'b1;
            end
            busy_len_q <= busy_o ? busy_len_q + 1'b1 : '0;
        end
    end

    // R6: programming starts only after exactly WINDOW cycles without an accepted write.
    a_r6_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (quiet_q == CNT_W'(WINDOW)));

    // R7: the busy phase lasts exactly PROG_CYCLES cycles.
    a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len_q == CNT_W'(PROG_CYCLES)));

endmodule

// File: rtl/pagemem_buf.sv
// Module: pagemem_buf
// Page buffer: one byte and one valid flag per page offset, plus the top bit
// of the most recently accepted byte. Valid flags clear on commit.
// Assumes: load_i and commit_i never arrive in the same cycle (the controller
// accepts no writes while programming).
module pagemem_buf #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [OFS_W-1:0]             ofs_i,
    input  logic [DATA_W-1:0]            din_i,
    input  logic                         commit_i,
    input  logic                         busy_i,
    output logic [(1<<OFS_W)-1:0]        valid_o,
    output logic [(1<<OFS_W)-1:0][DATA_W-1:0] data_o,
    output logic                         last_msb_o
);

    localparam int PAGE = 1 << OFS_W;

    logic [PAGE-1:0]             valid_q;
    logic [PAGE-1:0][DATA_W-1:0] data_q;
    logic                        last_msb_q;

    // Capture accepted bytes by offset; drop all flags once committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= '0;
            data_q     <= '0;
            last_msb_q <= 1'b0;
        end else if (commit_i) begin
            valid_q <= '0;
        end else if (load_i) begin
            valid_q[ofs_i] <= 1'b1;
            data_q[ofs_i]  <= din_i;
            last_msb_q     <= din_i[DATA_W-1];
        end
    end

    assign valid_o    = valid_q;
    assign data_o     = data_q;
    assign last_msb_o = last_msb_q;

    // R8: nothing enters the buffer while programming is under way.
    a_r8_buffer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !commit_i) |=> ($stable(valid_q) && $stable(data_q)));

endmodule

// File: rtl/pagemem_array.sv
// Module: pagemem_array
// Storage array with an asynchronous read port and a whole-page commit port.
// On commit, every buffered byte flagged valid replaces the stored byte.
// Assumes: the array is small enough for simulation (default 1 KiB).
module pagemem_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit_i,
    input  logic [ADDR_W-OFS_W-1:0]           page_i,
    input  logic [(1<<OFS_W)-1:0]             valid_i,
    input  logic [(1<<OFS_W)-1:0][DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0]                 rd_addr_i,
    output logic [DATA_W-1:0]                 rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << OFS_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Clear on reset; on commit, overwrite the loaded bytes of one page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (commit_i) begin
            for (int j = 0; j < PAGE; j++) begin
                if (valid_i[j]) begin
                    mem_q[{page_i, OFS_W'(j)}] <= data_i[j];
                end
            end
        end
    end

    // Read port: array byte at the presented address.
    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/pagemem_emu.sv
// Module: pagemem_emu (top)
// Byte-wide page-write memory emulator. It ties the controller, the page buffer
// and the array together and forms the read path. During programming, the read
// path substitutes the two polling bits for the top two data bits.
// Assumes: DATA_W >= 3 and ADDR_W > 8 (page offset is 8 bits).
module pagemem_emu
    import pagemem_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int WINDOW      = 8,
    parameter int PROG_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              out_en_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              busy
);

    localparam int OFS_W = 8;
    localparam int PG_W  = ADDR_W - OFS_W;
    localparam int PAGE  = 1 << OFS_W;

    pm_acc_e                     acc;
    logic                        load;
    logic                        commit;
    logic [PG_W-1:0]             page_q;
    logic [PAGE-1:0]             buf_valid;
    logic [PAGE-1:0][DATA_W-1:0] buf_data;
    logic                        last_msb;
    logic [DATA_W-1:0]           arr_data;
    logic                        tog_q;

    pagemem_ctrl #(
        .PG_W        (PG_W),
        .WINDOW      (WINDOW),
        .PROG_CYCLES (PROG_CYCLES)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .out_en_n (out_en_n),
        .wr_en_n  (wr_en_n),
        .page_i   (addr[ADDR_W-1:OFS_W]),
        .acc_o    (acc),
        .load_o   (load),
        .commit_o (commit),
        .busy_o   (busy),
        .page_o   (page_q)
    );

    pagemem_buf #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) buf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .ofs_i      (addr[OFS_W-1:0]),
        .din_i      (wdata),
        .commit_i   (commit),
        .busy_i     (busy),
        .valid_o    (buf_valid),
        .data_o     (buf_data),
        .last_msb_o (last_msb)
    );

    pagemem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .page_i    (page_q),
        .valid_i   (buf_valid),
        .data_i    (buf_data),
        .rd_addr_i (addr),
        .rd_data_o (arr_data)
    );

    // Toggle bit: parked at 0 outside programming, flips after each polled read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (!busy) begin
            tog_q <= 1'b0;
        end else if (acc == ACC_READ) begin
            tog_q <= ~tog_q;
        end
    end

    // Read path: array data, or polling status while programming.
    always_comb begin
        rdata    = '0;
        rdata_oe = (acc == ACC_READ);
        if (acc == ACC_READ) begin
            if (busy) begin
                rdata = {~last_msb, tog_q, arr_data[DATA_W-3:0]};
            end else begin
                rdata = arr_data;
            end
        end
    end

    // Checker state: was the previous cycle a polled read, and its bit 6.
    logic prev_poll_q;
    logic prev_b6_q;

    // Remember the last polled read for the toggle check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_poll_q <= 1'b0;
            prev_b6_q   <= 1'b0;
        end else begin
            prev_poll_q <= busy && rdata_oe;
            prev_b6_q   <= rdata[DATA_W-2];
        end
    end

    // R2: the bus is driven only by a read strobe combination.
    a_r2_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (!sel_n && !out_en_n && wr_en_n));

    // R3: an undriven bus carries zeros.
    a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));

    // R10: back-to-back polled reads show opposite toggle bits.
    a_r10_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rdata_oe && prev_poll_q) |-> (rdata[DATA_W-2] != prev_b6_q));

endmodule

// File: tb/pagemem_emu_tb_top.sv
// Scoreboard bench: the read driver queues expected bytes and a negedge monitor
// pops and compares them. The scenario code checks busy timing and no-effect cases.
module pagemem_emu_tb_top;

    localparam int ADDR_W      = 10;
    localparam int DATA_W      = 8;
    localparam int WINDOW      = 8;
    localparam int PROG_CYCLES = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_n = 1'b1;
    logic              out_en_n = 1'b1;
    logic              wr_en_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              rdata_oe;
    logic              busy;

    always #2ns clk = ~clk;

    pagemem_emu #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .WINDOW      (WINDOW),
        .PROG_CYCLES (PROG_CYCLES)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .out_en_n (out_en_n),
        .wr_en_n  (wr_en_n),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .rdata_oe (rdata_oe),
        .busy     (busy)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t   sb_q[$];
    sb_item_t   mon_item;
    bit         rd_drv = 1'b0;
    int         vec_cnt = 0;
    int         err_cnt = 0;
    bit         done = 1'b0;
    logic [7:0] mem_m [1<<ADDR_W];
    bit         last7 = 1'b0;
    int         poll_idx = 0;
    int         busy_len = 0;
    int         last_len = 0;
    int         rise_cnt = 0;
    bit         busy_d = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        vec_cnt++;
        if (!ok) begin
            err_cnt++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare reads against the scoreboard, track busy periods.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_drv) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R2", "scoreboard empty", 0, 1);
                end else begin
                    mon_item = sb_q.pop_front();
                    chk(rdata_oe === 1'b1, mon_item.tag, "rdata_oe", int'(rdata_oe), 1);
                    chk(rdata === mon_item.exp, mon_item.tag, "rdata", int'(rdata), int'(mon_item.exp));
                end
            end else if (rdata_oe !== 1'b0 || rdata !== 8'h00) begin
                chk(1'b0, "R3", "bus driven on non-read", int'(rdata), 0);
            end
            if (busy && !busy_d) rise_cnt++;
            if (busy) begin
                busy_len++;
            end else if (busy_d) begin
                last_len = busy_len;
                busy_len = 0;
            end
            busy_d = busy;
        end
    end

    task automatic drive(input bit s, input bit o, input bit w, input int a,
                         input int d, input bit is_rd);
        @(posedge clk);
        #1ns;
        sel_n    = s;
        out_en_n = o;
        wr_en_n  = w;
        addr     = a[ADDR_W-1:0];
        wdata    = d[7:0];
        rd_drv   = is_rd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b1, 1'b1, 0, 0, 1'b0);
    endtask

    task automatic wr(input int a, input int d);
        drive(1'b0, 1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic rd(input int a, input logic [7:0] exp, input string tag);
        sb_q.push_back('{exp, tag});
        drive(1'b0, 1'b0, 1'b1, a, 0, 1'b1);
    endtask

    // Polled read: inverted last top bit, toggle from read count, old low bits.
    task automatic poll(input int a, input string tag);
        logic [7:0] e;
        e = {~last7, poll_idx[0], mem_m[a][5:0]};
        rd(a, e, tag);
        poll_idx++;
    endtask

    task automatic wait_busy(output int n);
        idle(1);
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (busy) break;
            n++;
        end
        poll_idx = 0;
        #1ns;
    endtask

    task automatic wait_idle(input string tag);
        for (int k = 0; k < 1000; k++) begin
            idle(1);
            @(negedge clk);
            if (!busy) break;
        end
        #1ns;
        chk(last_len == PROG_CYCLES, tag, "busy length", last_len, PROG_CYCLES);
    endtask

    initial begin
        int n;
        int r0;
        for (int i = 0; i < (1 << ADDR_W); i++) mem_m[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy === 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(rdata_oe === 1'b0, "R1", "rdata_oe in reset", int'(rdata_oe), 0);
        @(posedge clk);
        #1ns;
        rst_n = 1'b1;
        idle(1);
        rd(12'h005, 8'h00, "R1");
        rd(12'h3FF, 8'h00, "R1");

        // Single-byte write, polling with a gap, then true data (R6 R9 R10 R11).
        wr(12'h005, 8'hA5);
        last7 = 1'b1;
        wait_busy(n);
        chk(n == WINDOW, "R6", "quiet cycles before busy", n, WINDOW);
        poll(12'h005, "R9");
        poll(12'h005, "R10");
        idle(1);
        poll(12'h005, "R10");
        wait_idle("R7");
        mem_m[12'h005] = 8'hA5;
        rd(12'h005, 8'hA5, "R11");

        // Page burst: foreign page, overwrite, late join, busy-time write (R4 R5 R6 R7 R8).
        wr(12'h110, 8'h11);
        wr(12'h111, 8'h22);
        wr(12'h210, 8'h99);
        wr(12'h111, 8'h77);
        rd(12'h110, 8'h00, "R7");
        idle(WINDOW - 2);
        wr(12'h1FF, 8'h80);
        last7 = 1'b1;
        wait_busy(n);
        chk(n == WINDOW, "R6", "quiet cycles after late join", n, WINDOW);
        poll(12'h110, "R9");
        wr(12'h120, 8'h55);
        wait_idle("R7");
        mem_m[12'h110] = 8'h11;
        mem_m[12'h111] = 8'h77;
        mem_m[12'h1FF] = 8'h80;
        rd(12'h110, 8'h11, "R4");
        rd(12'h111, 8'h77, "R4");
        rd(12'h1FF, 8'h80, "R6");
        rd(12'h210, 8'h00, "R5");
        rd(12'h120, 8'h00, "R8");
        r0 = rise_cnt;
        idle(WINDOW + PROG_CYCLES + 4);
        chk(rise_cnt == r0, "R8", "no phase from busy-time write", rise_cnt, r0);

        // Inhibit combinations (R3).
        r0 = rise_cnt;
        drive(1'b1, 1'b1, 1'b0, 12'h030, 8'hFF, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 12'h031, 8'hFF, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 12'h032, 8'hFF, 1'b0);
        idle(WINDOW + 4);
        chk(rise_cnt == r0, "R3", "no phase from inhibited strobes", rise_cnt, r0);
        rd(12'h030, 8'h00, "R3");
        rd(12'h031, 8'h00, "R3");

        // Overwrite without erase, top bit 0 polarity (R4 R9 R10).
        wr(12'h005, 8'h3C);
        last7 = 1'b0;
        wait_busy(n);
        chk(n == WINDOW, "R6", "quiet cycles single byte", n, WINDOW);
        poll(12'h005, "R9");
        poll(12'h005, "R10");
        wait_idle("R7");
        mem_m[12'h005] = 8'h3C;
        rd(12'h005, 8'h3C, "R4");

        idle(3);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    end

    initial begin
        #400us;
        if (!done) begin
            done = 1'b1;
            vec_cnt++;
            err_cnt++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    end

endmodule